// File: doc/BRIEF.md
# Repeated Primitive Suppression Codec

This block sits in a link-layer transmit and receive path. On the transmit side it takes one request per clock: a primitive code, or a 32-bit data word. It turns the request into a 32-bit line word with a control flag. When one primitive is requested on many consecutive clocks, the line would carry the same control symbol for a long time, and that raises a sharp peak in the emitted spectrum. To avoid this, the block sends the primitive twice, then a continuation marker, then pseudo-random filler words flagged as data, for as long as the run lasts.

The receive side undoes this. It reports each primitive it receives to the link state machine. After a continuation marker it keeps reporting the last primitive on every clock, whatever words arrive, until a different primitive ends the hold. Alignment primitives belong to the physical layer. This side never reports them, and they do not end a hold. The two sides are independent, so a bench or a loopback can connect the line output to the line input.

Top module: `repsup_top`

## Requirements
- R1: A primitive request appears one clock later on the line as `lineIsCtrl`=1 with `lineWord` = {24'h7CB5B5, 4'h0, code}. A data request appears one clock later with `lineIsCtrl`=0 and the word unchanged. An idle cycle (`txReqValid`=0) gives `lineValid`=0. The primitive codes are: 0 SYNC, 1 HOLD, 2 HOLDA, 3 R_RDY, 4 X_RDY, 5 R_IP, 6 R_OK, 7 R_ERR, 8 WTRM, 9 DMAT, 10 SOF, 11 EOF, 12 CONT (continuation marker) and 13 ALIGN.
- R2: Codes 0 to 9 may be suppressed. When one of them is requested on consecutive clocks, the first two requests are sent as that primitive, the third is sent as the CONT control word, and every further request in the run is sent as a filler word.
- R3: Filler words carry `lineIsCtrl`=0, and two consecutive filler words differ.
- R4: SOF, EOF, CONT, ALIGN and the unused codes 14 and 15 are always sent as their own control word, even when repeated. They also restart the repeat count.
- R5: A different primitive, a data request or an idle cycle ends a run. A later repeated primitive is counted afresh from its first copy.
- R6: On receive, a control word with code 0 to 12 other than CONT is reported one clock later on `rxPrimValid`/`rxPrimCode` (code = `rxWord[3:0]`). A data word received outside a hold is reported one clock later on `rxDataValid`/`rxData`.
- R7: A CONT received after a reported code 0 to 9 starts a hold. From then on, the held code is reported on every clock, whether the input is a data word, no word, or another CONT. This continues until a control word other than CONT or ALIGN arrives, and that word is then reported.
- R8: A received ALIGN is never reported, and it does not end a hold.
- R9: A received CONT is ignored when no code 0 to 9 has been reported since the last reset, SOF, EOF or data word.
- R10: Reset clears all outputs and all run and hold state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| txReqValid | input | 1 | A transmit request is present this clock |
| txReqPrim | input | 1 | 1: the request is a primitive; 0: the request is data |
| txReqCode | input | 4 | Requested primitive code |
| txReqData | input | 32 | Requested data word |
| lineValid | output | 1 | A line word is present |
| lineIsCtrl | output | 1 | The line word is a control word |
| lineWord | output | 32 | Word toward the line |
| rxWordValid | input | 1 | A received line word is present |
| rxIsCtrl | input | 1 | The received word is a control word |
| rxWord | input | 32 | Received line word |
| rxPrimValid | output | 1 | A primitive is reported |
| rxPrimCode | output | 4 | Reported primitive code |
| rxDataValid | output | 1 | A data word is reported |
| rxData | output | 32 | Reported data word |

## Verification
The line output is looped back into the receive input and driven with several kinds of run. There is a long run that reaches filler, a run of two that ends just before the marker, and a run cut off by an idle cycle and then by a data word. There is also a run of repeated frame delimiters. These tell apart a counter that fires early or late, a delimiter that is wrongly suppressed, and a receiver that stops holding or keeps holding too long. Directed receive sequences then place ALIGN inside a hold and outside one, send CONT with no prior primitive and after data, and apply reset in the middle of a hold. These separate "ignored" from "ends the hold".

// File: rtl/repsup_pkg.sv
package repsup_pkg;

  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] PC_SYNC       = 4'd0;
  localparam logic [CODE_W-1:0] PC_HOLD       = 4'd1;
  localparam logic [CODE_W-1:0] PC_HOLDACK    = 4'd2;
  localparam logic [CODE_W-1:0] PC_RXREADY    = 4'd3;
  localparam logic [CODE_W-1:0] PC_TXREADY    = 4'd4;
  localparam logic [CODE_W-1:0] PC_RXBUSY     = 4'd5;
  localparam logic [CODE_W-1:0] PC_RXGOOD     = 4'd6;
  localparam logic [CODE_W-1:0] PC_RXBAD      = 4'd7;
  localparam logic [CODE_W-1:0] PC_AWAITSTAT  = 4'd8;
  localparam logic [CODE_W-1:0] PC_ABORT      = 4'd9;
  localparam logic [CODE_W-1:0] PC_FRAMESTART = 4'd10;
  localparam logic [CODE_W-1:0] PC_FRAMEEND   = 4'd11;
  localparam logic [CODE_W-1:0] PC_REPEAT     = 4'd12;
  localparam logic [CODE_W-1:0] PC_ALIGN      = 4'd13;

  // Transmit word source chosen by the control
  typedef enum logic [2:0] {
    TXS_NONE, TXS_PRIM, TXS_CONT, TXS_FILL, TXS_DATA
  } txSel_e;

  // Receive report source chosen by the control
  typedef enum logic [1:0] {
    RXS_NONE, RXS_PRIM, RXS_HELD, RXS_DATA
  } rxSel_e;

  typedef enum logic [1:0] {
    TX_IDLE, TX_ONCE, TX_TWICE, TX_SUPP
  } txState_e;

  typedef enum logic [1:0] {
    RX_FREE, RX_LAST, RX_HOLD
  } rxState_e;

  typedef struct packed {
    txSel_e txSel;
    logic   txLoadLast;
    rxSel_e rxSel;
    logic   rxLoadLast;
  } strobes_t;

  // Codes that may be compressed into a run
  function automatic logic isRunnable(input logic [CODE_W-1:0] code);
    return code <= PC_ABORT;
  endfunction

endpackage

// File: rtl/repsup_ctrl.sv
module repsup_ctrl
  import repsup_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              txReqValid,
  input  logic              txReqPrim,
  input  logic [CODE_W-1:0] txReqCode,
  input  logic              txSame,
  input  logic              rxWordValid,
  input  logic              rxIsCtrl,
  input  logic [CODE_W-1:0] rxCode,
  output strobes_t          strb
);

  txState_e txState, txNext;
  rxState_e rxState, rxNext;

  // Transmit run tracking
  always_comb begin
    txNext          = txState;
    strb.txSel      = TXS_NONE;
    strb.txLoadLast = 1'b0;
    if (!txReqValid) begin
      txNext = TX_IDLE;
    end else if (!txReqPrim) begin
      strb.txSel = TXS_DATA;
      txNext     = TX_IDLE;
    end else if (!isRunnable(txReqCode)) begin
      strb.txSel = TXS_PRIM;
      txNext     = TX_IDLE;
    end else if (txSame && txState != TX_IDLE) begin
      unique case (txState)
        TX_ONCE: begin
          strb.txSel = TXS_PRIM;
          txNext     = TX_TWICE;
        end
        TX_TWICE: begin
          strb.txSel = TXS_CONT;
          txNext     = TX_SUPP;
        end
        default: begin
          strb.txSel = TXS_FILL;
          txNext     = TX_SUPP;
        end
      endcase
    end else begin
      strb.txSel      = TXS_PRIM;
      strb.txLoadLast = 1'b1;
      txNext          = TX_ONCE;
    end
  end

  // Receive hold tracking
  always_comb begin
    rxNext          = rxState;
    strb.rxSel      = (rxState == RX_HOLD) ? RXS_HELD : RXS_NONE;
    strb.rxLoadLast = 1'b0;
    if (rxWordValid && rxIsCtrl) begin
      if (rxCode == PC_ALIGN) begin
        rxNext = rxState;
      end else if (rxCode == PC_REPEAT) begin
        if (rxState != RX_FREE) begin
          strb.rxSel = RXS_HELD;
          rxNext     = RX_HOLD;
        end
      end else if (isRunnable(rxCode)) begin
        strb.rxSel      = RXS_PRIM;
        strb.rxLoadLast = 1'b1;
        rxNext          = RX_LAST;
      end else begin
        strb.rxSel = RXS_PRIM;
        rxNext     = RX_FREE;
      end
    end else if (rxWordValid && rxState != RX_HOLD) begin
      strb.rxSel = RXS_DATA;
      rxNext     = RX_FREE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txState <= TX_IDLE;
      rxState <= RX_FREE;
    end else begin
      txState <= txNext;
      rxState <= rxNext;
    end
  end

  // A hold is only ever entered on a received continuation marker
  assert_hold_entry_R7: assert property (@(posedge clk) disable iff (rst)
    (rxState == RX_HOLD && $past(rxState) != RX_HOLD)
      |-> $past(rxWordValid && rxIsCtrl && rxCode == PC_REPEAT));

  // A marker with nothing reported before it never starts a hold
  assert_cont_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (rxState == RX_FREE && rxWordValid && rxIsCtrl && rxCode == PC_REPEAT)
      |=> rxState == RX_FREE);

endmodule

// File: rtl/repsup_dpath.sv
module repsup_dpath
  import repsup_pkg::*;
#(
  parameter int                   WORD_W    = 32,
  parameter int                   LFSR_W    = 16,
  parameter logic [LFSR_W-1:0]    LFSR_TAPS = 16'hF008,
  parameter logic [LFSR_W-1:0]    LFSR_SEED = 16'hACE1,
  parameter logic [WORD_W-9:0]    PRIM_TAG  = 24'h7CB5B5
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          strb,
  input  logic              txReqValid,
  input  logic              txReqPrim,
  input  logic [CODE_W-1:0] txReqCode,
  input  logic [WORD_W-1:0] txReqData,
  input  logic              rxWordValid,
  input  logic              rxIsCtrl,
  input  logic [WORD_W-1:0] rxWord,
  output logic              txSame,
  output logic              lineValid,
  output logic              lineIsCtrl,
  output logic [WORD_W-1:0] lineWord,
  output logic              rxPrimValid,
  output logic [CODE_W-1:0] rxPrimCode,
  output logic              rxDataValid,
  output logic [WORD_W-1:0] rxData
);

  localparam logic [3:0] PAD = 4'h0;

  logic [CODE_W-1:0] txLastCode;
  logic [CODE_W-1:0] rxLastCode;
  logic [LFSR_W-1:0] lfsrQ;
  logic              lfsrFb;
  logic [WORD_W-1:0] fillWord;

  assign txSame = (txReqCode == txLastCode);
  assign lfsrFb = ^(lfsrQ & LFSR_TAPS);

  // Filler spreads the LFSR over the word, inverting alternate copies
  always_comb begin
    for (int i = 0; i < WORD_W; i++) begin
      fillWord[i] = lfsrQ[i % LFSR_W] ^ (((i / LFSR_W) % 2) != 0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsrQ      <= LFSR_SEED;
      txLastCode <= '0;
      rxLastCode <= '0;
    end else begin
      lfsrQ <= {lfsrQ[LFSR_W-2:0], lfsrFb};
      if (strb.txLoadLast) txLastCode <= txReqCode;
      if (strb.rxLoadLast) rxLastCode <= rxWord[CODE_W-1:0];
    end
  end

  // Line output register
  always_ff @(posedge clk) begin
    if (rst) begin
      lineValid  <= 1'b0;
      lineIsCtrl <= 1'b0;
      lineWord   <= '0;
    end else begin
      unique case (strb.txSel)
        TXS_PRIM: begin
          lineValid  <= 1'b1;
          lineIsCtrl <= 1'b1;
          lineWord   <= {PRIM_TAG, PAD, txReqCode};
        end
        TXS_CONT: begin
          lineValid  <= 1'b1;
          lineIsCtrl <= 1'b1;
          lineWord   <= {PRIM_TAG, PAD, PC_REPEAT};
        end
        TXS_FILL: begin
          lineValid  <= 1'b1;
          lineIsCtrl <= 1'b0;
          lineWord   <= fillWord;
        end
        TXS_DATA: begin
          lineValid  <= 1'b1;
          lineIsCtrl <= 1'b0;
          lineWord   <= txReqData;
        end
        default: begin
          lineValid  <= 1'b0;
          lineIsCtrl <= 1'b0;
          lineWord   <= '0;
        end
      endcase
    end
  end

  // Receive report register
  always_ff @(posedge clk) begin
    if (rst) begin
      rxPrimValid <= 1'b0;
      rxPrimCode  <= '0;
      rxDataValid <= 1'b0;
      rxData      <= '0;
    end else begin
      rxPrimValid <= 1'b0;
      rxPrimCode  <= '0;
      rxDataValid <= 1'b0;
      rxData      <= '0;
      unique case (strb.rxSel)
        RXS_PRIM: begin
          rxPrimValid <= 1'b1;
          rxPrimCode  <= rxWord[CODE_W-1:0];
        end
        RXS_HELD: begin
          rxPrimValid <= 1'b1;
          rxPrimCode  <= rxLastCode;
        end
        RXS_DATA: begin
          rxDataValid <= 1'b1;
          rxData      <= rxWord;
        end
        default: ;
      endcase
    end
  end

  // The marker goes out only after two identical control words
  assert_cont_after_pair_R2: assert property (@(posedge clk) disable iff (rst)
    (strb.txSel == TXS_CONT)
      |-> (lineValid && lineIsCtrl && $past(lineValid) && $past(lineIsCtrl)
           && lineWord == $past(lineWord)));

  assert_fill_is_data_R3: assert property (@(posedge clk) disable iff (rst)
    (strb.txSel == TXS_FILL) |=> (lineValid && !lineIsCtrl));

  assert_delim_verbatim_R4: assert property (@(posedge clk) disable iff (rst)
    (txReqValid && txReqPrim && (txReqCode == PC_FRAMESTART || txReqCode == PC_FRAMEEND))
      |=> (lineValid && lineIsCtrl && lineWord[CODE_W-1:0] == $past(txReqCode)));

  assert_align_hidden_R8: assert property (@(posedge clk) disable iff (rst)
    (rxWordValid && rxIsCtrl && rxWord[CODE_W-1:0] == PC_ALIGN)
      |=> !(rxPrimValid && rxPrimCode == PC_ALIGN));

endmodule

// File: rtl/repsup_top.sv
module repsup_top
  import repsup_pkg::*;
#(
  parameter int                WORD_W    = 32,
  parameter int                LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hF008,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  parameter logic [WORD_W-9:0] PRIM_TAG  = 24'h7CB5B5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txReqValid,
  input  logic              txReqPrim,
  input  logic [CODE_W-1:0] txReqCode,
  input  logic [WORD_W-1:0] txReqData,
  output logic              lineValid,
  output logic              lineIsCtrl,
  output logic [WORD_W-1:0] lineWord,
  input  logic              rxWordValid,
  input  logic              rxIsCtrl,
  input  logic [WORD_W-1:0] rxWord,
  output logic              rxPrimValid,
  output logic [CODE_W-1:0] rxPrimCode,
  output logic              rxDataValid,
  output logic [WORD_W-1:0] rxData
);

  strobes_t strb;
  logic     txSame;

  repsup_ctrl uCtrl (
    .clk         (clk),
    .rst         (rst),
    .txReqValid  (txReqValid),
    .txReqPrim   (txReqPrim),
    .txReqCode   (txReqCode),
    .txSame      (txSame),
    .rxWordValid (rxWordValid),
    .rxIsCtrl    (rxIsCtrl),
    .rxCode      (rxWord[CODE_W-1:0]),
    .strb        (strb)
  );

  repsup_dpath #(
    .WORD_W    (WORD_W),
    .LFSR_W    (LFSR_W),
    .LFSR_TAPS (LFSR_TAPS),
    .LFSR_SEED (LFSR_SEED),
    .PRIM_TAG  (PRIM_TAG)
  ) uDpath (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .txReqValid  (txReqValid),
    .txReqPrim   (txReqPrim),
    .txReqCode   (txReqCode),
    .txReqData   (txReqData),
    .rxWordValid (rxWordValid),
    .rxIsCtrl    (rxIsCtrl),
    .rxWord      (rxWord),
    .txSame      (txSame),
    .lineValid   (lineValid),
    .lineIsCtrl  (lineIsCtrl),
    .lineWord    (lineWord),
    .rxPrimValid (rxPrimValid),
    .rxPrimCode  (rxPrimCode),
    .rxDataValid (rxDataValid),
    .rxData      (rxData)
  );

endmodule

// File: tb/sim_repsup_top.sv
module sim_repsup_top;

  localparam logic [23:0] TAG = 24'h7CB5B5;
  localparam int LX_NONE = 0, LX_PRIM = 1, LX_CONT = 2, LX_FILL = 3, LX_DATA = 4;
  localparam int RE_NONE = 0, RE_PRIM = 1, RE_DATA = 2;

  typedef struct packed {
    logic        v;
    logic        p;
    logic [3:0]  code;
    logic [31:0] data;
    logic [2:0]  lx;
    logic [1:0]  re;
    logic [3:0]  reCode;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 4'd0,  32'h0,        3'd1, 2'd1, 4'd0},  // 0 SYNC
    '{1'b1, 1'b1, 4'd0,  32'h0,        3'd1, 2'd1, 4'd0},  // 1 SYNC again
    '{1'b1, 1'b1, 4'd0,  32'h0,        3'd2, 2'd1, 4'd0},  // 2 marker R2
    '{1'b1, 1'b1, 4'd0,  32'h0,        3'd3, 2'd1, 4'd0},  // 3 filler R3
    '{1'b1, 1'b1, 4'd0,  32'h0,        3'd3, 2'd1, 4'd0},  // 4 filler
    '{1'b1, 1'b1, 4'd4,  32'h0,        3'd1, 2'd1, 4'd4},  // 5 new prim ends hold
    '{1'b1, 1'b1, 4'd4,  32'h0,        3'd1, 2'd1, 4'd4},  // 6
    '{1'b1, 1'b1, 4'd3,  32'h0,        3'd1, 2'd1, 4'd3},  // 7 R5 change before marker
    '{1'b1, 1'b1, 4'd3,  32'h0,        3'd1, 2'd1, 4'd3},  // 8
    '{1'b1, 1'b1, 4'd3,  32'h0,        3'd2, 2'd1, 4'd3},  // 9 marker
    '{1'b1, 1'b1, 4'd10, 32'h0,        3'd1, 2'd1, 4'd10}, // 10 SOF
    '{1'b1, 1'b0, 4'd0,  32'h12345678, 3'd4, 2'd2, 4'd0},  // 11 data
    '{1'b1, 1'b0, 4'd0,  32'hCAFEF00D, 3'd4, 2'd2, 4'd0},  // 12 data
    '{1'b1, 1'b1, 4'd11, 32'h0,        3'd1, 2'd1, 4'd11}, // 13 EOF R4
    '{1'b1, 1'b1, 4'd11, 32'h0,        3'd1, 2'd1, 4'd11}, // 14 EOF
    '{1'b1, 1'b1, 4'd11, 32'h0,        3'd1, 2'd1, 4'd11}, // 15 EOF not suppressed
    '{1'b1, 1'b1, 4'd8,  32'h0,        3'd1, 2'd1, 4'd8},  // 16 WTRM
    '{1'b1, 1'b1, 4'd8,  32'h0,        3'd1, 2'd1, 4'd8},  // 17
    '{1'b1, 1'b1, 4'd8,  32'h0,        3'd2, 2'd1, 4'd8},  // 18 marker
    '{1'b1, 1'b1, 4'd8,  32'h0,        3'd3, 2'd1, 4'd8},  // 19 filler
    '{1'b0, 1'b0, 4'd0,  32'h0,        3'd0, 2'd1, 4'd8},  // 20 idle: R7 held still reported
    '{1'b1, 1'b1, 4'd6,  32'h0,        3'd1, 2'd1, 4'd6},  // 21 R5 counted afresh
    '{1'b1, 1'b1, 4'd6,  32'h0,        3'd1, 2'd1, 4'd6},  // 22
    '{1'b1, 1'b1, 4'd6,  32'h0,        3'd2, 2'd1, 4'd6},  // 23 marker
    '{1'b1, 1'b0, 4'd0,  32'h0BADBEEF, 3'd4, 2'd1, 4'd6},  // 24 R5 data ends tx run; rx holds
    '{1'b1, 1'b1, 4'd1,  32'h0,        3'd1, 2'd1, 4'd1},  // 25 HOLD
    '{1'b0, 1'b0, 4'd0,  32'h0,        3'd0, 2'd0, 4'd0},  // 26 idle, no hold
    '{1'b1, 1'b1, 4'd13, 32'h0,        3'd1, 2'd0, 4'd0}   // 27 ALIGN sent, not reported
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        txReqValid = 1'b0, txReqPrim = 1'b0;
  logic [3:0]  txReqCode = '0;
  logic [31:0] txReqData = '0;
  logic        lineValid, lineIsCtrl;
  logic [31:0] lineWord;
  logic        loopBack = 1'b1;
  logic        bRxValid = 1'b0, bRxCtrl = 1'b0;
  logic [31:0] bRxWord = '0;
  logic        rxWordValid, rxIsCtrl;
  logic [31:0] rxWord;
  logic        rxPrimValid, rxDataValid;
  logic [3:0]  rxPrimCode;
  logic [31:0] rxData;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  assign rxWordValid = loopBack ? lineValid  : bRxValid;
  assign rxIsCtrl    = loopBack ? lineIsCtrl : bRxCtrl;
  assign rxWord      = loopBack ? lineWord   : bRxWord;

  repsup_top u0 (
    .clk(clk), .rst(rst),
    .txReqValid(txReqValid), .txReqPrim(txReqPrim),
    .txReqCode(txReqCode), .txReqData(txReqData),
    .lineValid(lineValid), .lineIsCtrl(lineIsCtrl), .lineWord(lineWord),
    .rxWordValid(rxWordValid), .rxIsCtrl(rxIsCtrl), .rxWord(rxWord),
    .rxPrimValid(rxPrimValid), .rxPrimCode(rxPrimCode),
    .rxDataValid(rxDataValid), .rxData(rxData)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkRx(input string req, input int kind, input logic [3:0] code,
                         input logic [31:0] data);
    logic [63:0] act, exp;
    act = {23'd0, rxPrimValid, rxPrimCode, rxDataValid, rxData};
    exp = {23'd0, kind == RE_PRIM, (kind == RE_PRIM) ? code : 4'd0,
           kind == RE_DATA, (kind == RE_DATA) ? data : 32'd0};
    check(act == exp, req, act, exp);
  endtask

  task automatic rxDrive(input logic v, input logic c, input logic [31:0] w);
    bRxValid = v;
    bRxCtrl  = c;
    bRxWord  = w;
  endtask

  task automatic rxStep(input logic v, input logic c, input logic [31:0] w,
                        input string req, input int kind, input logic [3:0] code,
                        input logic [31:0] data);
    rxDrive(v, c, w);
    @(negedge clk);
    checkRx(req, kind, code, data);
  endtask

  initial begin
    #(4 * 20000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] prevFill;
    bit          prevWasFill;
    logic [63:0] act, exp;
    string       tag;

    repeat (3) @(negedge clk);
    // R10 reset state
    check({lineValid, lineIsCtrl, lineWord} == 34'd0, "R10", {30'd0, lineValid, lineIsCtrl, lineWord}, 64'd0);
    checkRx("R10", RE_NONE, 4'd0, 32'd0);
    rst = 1'b0;

    prevWasFill = 1'b0;
    prevFill    = '0;
    for (int i = 0; i < NV; i++) begin
      txReqValid = VECS[i].v;
      txReqPrim  = VECS[i].p;
      txReqCode  = VECS[i].code;
      txReqData  = VECS[i].data;
      @(negedge clk);
      act = {30'd0, lineValid, lineIsCtrl, lineWord};
      case (int'(VECS[i].lx))
        LX_PRIM: begin exp = {30'd0, 1'b1, 1'b1, TAG, 4'h0, VECS[i].code}; tag = "R1/R4"; end
        LX_CONT: begin exp = {30'd0, 1'b1, 1'b1, TAG, 4'h0, 4'd12}; tag = "R2"; end
        LX_FILL: begin exp = {30'd0, 1'b1, 1'b0, lineWord}; tag = "R3"; end
        LX_DATA: begin exp = {30'd0, 1'b1, 1'b0, VECS[i].data}; tag = "R1/R5"; end
        default: begin exp = 64'd0; tag = "R1/R5"; end
      endcase
      check(act == exp, tag, act, exp);
      if (int'(VECS[i].lx) == LX_FILL) begin
        if (prevWasFill) check(lineWord != prevFill, "R3", {32'd0, lineWord}, {32'd0, ~prevFill});
        prevWasFill = 1'b1;
        prevFill    = lineWord;
      end else begin
        prevWasFill = 1'b0;
      end
      if (i > 0) checkRx("R6/R7", int'(VECS[i-1].re), VECS[i-1].reCode, VECS[i-1].data);
    end
    txReqValid = 1'b0;
    @(negedge clk);
    checkRx("R8", int'(VECS[NV-1].re), VECS[NV-1].reCode, VECS[NV-1].data);

    // Directed receive sequences
    loopBack = 1'b0;
    rxStep(1'b1, 1'b1, {TAG, 4'h0, 4'd9}, "R6", RE_PRIM, 4'd9, 32'd0);
    rxStep(1'b1, 1'b1, {TAG, 4'h0, 4'd12}, "R7", RE_PRIM, 4'd9, 32'd0);
    rxStep(1'b1, 1'b1, {TAG, 4'h0, 4'd13}, "R8", RE_PRIM, 4'd9, 32'd0);
    rxStep(1'b1, 1'b0, 32'h11112222, "R7", RE_PRIM, 4'd9, 32'd0);
    rxStep(1'b0, 1'b0, 32'h0, "R7", RE_PRIM, 4'd9, 32'd0);
    rxStep(1'b1, 1'b1, {TAG, 4'h0, 4'd12}, "R7", RE_PRIM, 4'd9, 32'd0);
    rxStep(1'b1, 1'b1, {TAG, 4'h0, 4'd7}, "R7", RE_PRIM, 4'd7, 32'd0);
    rxStep(1'b1, 1'b1, {TAG, 4'h0, 4'd13}, "R8", RE_NONE, 4'd0, 32'd0);
    rxStep(1'b1, 1'b1, {TAG, 4'h0, 4'd10}, "R6", RE_PRIM, 4'd10, 32'd0);
    rxStep(1'b1, 1'b1, {TAG, 4'h0, 4'd12}, "R9", RE_NONE, 4'd0, 32'd0);
    rxStep(1'b1, 1'b0, 32'hABCD0123, "R6", RE_DATA, 4'd0, 32'hABCD0123);
    rxStep(1'b1, 1'b1, {TAG, 4'h0, 4'd12}, "R9", RE_NONE, 4'd0, 32'd0);
    rxStep(1'b1, 1'b1, {TAG, 4'h0, 4'd2}, "R6", RE_PRIM, 4'd2, 32'd0);
    rxStep(1'b1, 1'b1, {TAG, 4'h0, 4'd12}, "R7", RE_PRIM, 4'd2, 32'd0);

    // R10 reset in the middle of a hold and of a transmit run
    txReqValid = 1'b1; txReqPrim = 1'b1; txReqCode = 4'd5;
    rxDrive(1'b0, 1'b0, 32'h0);
    rst = 1'b1;
    @(negedge clk);
    check({lineValid, lineIsCtrl} == 2'b00, "R10", {62'd0, lineValid, lineIsCtrl}, 64'd0);
    checkRx("R10", RE_NONE, 4'd0, 32'd0);
    rst = 1'b0;
    txReqValid = 1'b0;
    rxStep(1'b1, 1'b1, {TAG, 4'h0, 4'd12}, "R9", RE_NONE, 4'd0, 32'd0);
    rxStep(1'b0, 1'b0, 32'h0, "R10", RE_NONE, 4'd0, 32'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule